// File: doc/BRIEF.md
# Raster-Op Rectangle Copy Engine

This block moves a rectangle of pixels from one surface to another inside a byte-addressed linear memory. Each destination pixel is replaced by a bitwise combination of itself and the matching source pixel, chosen by an 8-bit raster code. Software-side logic presents a single command on a valid/ready port. The command carries the pixel size, both base addresses, both pitches, the source start point, the destination rectangle corners and the raster code. The engine then walks the rectangle and raises a one-cycle completion pulse.

Pixels are 1, 2 or 4 bytes wide. The source pitch is a signed 16-bit value. A negative source pitch steps the source upward in memory, which yields a vertically mirrored copy. For 4-byte pixels, two enables choose separately whether the top (alpha) byte and the three lower (colour) bytes are stored. The memory port moves one pixel per access and reads with one cycle of latency, so each pixel costs a source read, a destination read and a write.

Top module: `rop_rect_copy`

## Requirements
- R1: Every result bit equals raster-code bit number {0, s, d}, where s and d are the matching source and destination bits and the pattern index bit is 0. Hence 0xCC copies, 0xAA keeps the destination, 0x66 is xor, 0x88 and, 0xEE or, 0x11 nor, 0x99 equiv, 0x55 invert, 0x77 nand, 0x00 clear and 0xFF set.
- R2: Pixel sizes 1, 2 and 4 bytes are supported. Pixel (x, y) of a surface lies at base + y*pitch + x*size, modulo the address width. The pixel's byte at the lowest address is data bits 7:0, and mem_size carries the pixel size on every access.
- R3: The destination rectangle spans x1 <= x < x2 and y1 <= y < y2, with corners packed as {y[15:0], x[15:0]}. Source pixel (sx+i, sy+j) pairs with destination pixel (x1+i, y1+j). Rows are visited top to bottom and pixels left to right. Each pixel is written exactly once, after its destination read.
- R4: A negative source pitch (two's complement) makes each later source row lie one pitch magnitude lower in memory, which gives a vertically flipped copy. The pitch value -32768 is legal.
- R5: For 4-byte pixels, byte 3 is stored only when the alpha enable is set, and bytes 2..0 only when the colour enable is set. For 1- and 2-byte pixels all pixel bytes are stored, whatever the enables say.
- R6: A legal command with x2 <= x1 or y2 <= y1 completes with done and err = 0. It performs no memory writes and busy never rises.
- R7: A command is rejected in the following cases: the pixel size is not 1, 2 or 4; either pitch is not a multiple of 4; or the destination pitch exceeds 32768. A rejected command raises done with err = 1 and performs no writes.
- R8: cmd_ready is low and busy is high from the accept of a non-empty legal command until its last write. done pulses for exactly one cycle after that write. err holds its value until the next accepted command.
- R9: After reset, busy = 0, cmd_ready = 1, done = 0, err = 0, and no memory access is made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Engine can accept a command |
| cmd_bpp | input | 3 | Bytes per pixel |
| cmd_rop | input | 8 | Raster code |
| cmd_wr_alpha | input | 1 | Store byte 3 of 4-byte pixels |
| cmd_wr_rgb | input | 1 | Store bytes 2..0 of 4-byte pixels |
| cmd_src_base | input | AW | Source surface base address |
| cmd_dst_base | input | AW | Destination surface base address |
| cmd_src_pitch | input | 16 | Signed source row pitch in bytes |
| cmd_dst_pitch | input | 16 | Unsigned destination row pitch in bytes |
| cmd_src_xy | input | 32 | Source start {y, x} |
| cmd_dst_xy1 | input | 32 | Destination top-left {y, x} |
| cmd_dst_xy2 | input | 32 | Destination exclusive bottom-right {y, x} |
| busy | output | 1 | Rectangle walk in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Last command was rejected |
| mem_re | output | 1 | Memory read strobe |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | AW | Pixel byte address |
| mem_size | output | 3 | Pixel size of the access |
| mem_be | output | 4 | Byte write enables, relative to the pixel |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid the cycle after mem_re |

## Verification
The bench builds the engine with AW = 12, which is a 4 KB memory. Because addresses wrap at that width, the extreme pitches still fall inside the bench memory. A source pitch of -32768 and a destination pitch of 32768 alias rows onto the same addresses, so both limits of the legal pitch range are exercised. The rule that splits accept from reject can be tested on each side of its boundary. After every command, the whole memory is compared against a byte-level model of the same walk.

// File: rtl/rce_pkg.sv
package rce_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RD_SRC,
    ST_RD_DST,
    ST_WR
  } rce_state_e;

  localparam int DATA_W   = 32;
  localparam int BYTES_W  = DATA_W / 8;
  localparam int COORD_W  = 16;
  localparam logic [15:0] PITCH_MAX = 16'h8000;

  function automatic logic size_ok(input logic [2:0] bpp);
    return (bpp == 3'd1) || (bpp == 3'd2) || (bpp == 3'd4);
  endfunction

  function automatic logic [BYTES_W-1:0] store_mask(input logic [2:0] bpp,
                                                    input logic wa,
                                                    input logic wrgb);
    logic [BYTES_W-1:0] m;
    case (bpp)
      3'd4:    m = {wa, wrgb, wrgb, wrgb};
      3'd2:    m = 4'b0011;
      default: m = 4'b0001;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/rce_rop.sv
module rce_rop #(
  parameter int DW = 32
) (
  input  logic [7:0]    code,
  input  logic [DW-1:0] src,
  input  logic [DW-1:0] dst,
  output logic [DW-1:0] res
);

  // Pattern index bit is tied to zero: only the low nibble of the code is live.
  for (genvar i = 0; i < DW; i++) begin : g_bit
    assign res[i] = code[{1'b0, src[i], dst[i]}];
  end

endmodule

// File: rtl/rce_setup.sv
module rce_setup
  import rce_pkg::*;
#(
  parameter int AW = 24
) (
  input  logic [2:0]         bpp,
  input  logic               wr_alpha,
  input  logic               wr_rgb,
  input  logic [AW-1:0]      src_base,
  input  logic [AW-1:0]      dst_base,
  input  logic [15:0]        src_pitch,
  input  logic [15:0]        dst_pitch,
  input  logic [31:0]        src_xy,
  input  logic [31:0]        dst_xy1,
  input  logic [31:0]        dst_xy2,
  output logic               legal,
  output logic               empty,
  output logic [COORD_W-1:0] width,
  output logic [COORD_W-1:0] height,
  output logic [AW-1:0]      src_start,
  output logic [AW-1:0]      dst_start,
  output logic [AW-1:0]      src_step,
  output logic [AW-1:0]      dst_step,
  output logic [BYTES_W-1:0] be
);

  logic [31:0] src_pitch_sx;
  logic [AW-1:0] bpp_a;

  always_comb begin
    src_pitch_sx = {{16{src_pitch[15]}}, src_pitch};
    bpp_a        = AW'(bpp);

    legal = size_ok(bpp) && (src_pitch[1:0] == 2'b00) &&
            (dst_pitch[1:0] == 2'b00) && (dst_pitch <= PITCH_MAX);
    empty = (dst_xy2[15:0] <= dst_xy1[15:0]) || (dst_xy2[31:16] <= dst_xy1[31:16]);

    width  = dst_xy2[15:0]  - dst_xy1[15:0];
    height = dst_xy2[31:16] - dst_xy1[31:16];

    src_step = AW'(src_pitch_sx);
    dst_step = AW'(dst_pitch);

    src_start = src_base + AW'(src_xy[31:16]) * src_step + AW'(src_xy[15:0]) * bpp_a;
    dst_start = dst_base + AW'(dst_xy1[31:16]) * dst_step + AW'(dst_xy1[15:0]) * bpp_a;

    be = store_mask(bpp, wr_alpha, wr_rgb);
  end

endmodule

// File: rtl/rce_walk.sv
module rce_walk
  import rce_pkg::*;
#(
  parameter int AW = 24
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               load,
  input  logic               step,
  input  logic [2:0]         bpp,
  input  logic [COORD_W-1:0] width,
  input  logic [COORD_W-1:0] height,
  input  logic [AW-1:0]      src_start,
  input  logic [AW-1:0]      dst_start,
  input  logic [AW-1:0]      src_step,
  input  logic [AW-1:0]      dst_step,
  output logic [AW-1:0]      src_ptr,
  output logic [AW-1:0]      dst_ptr,
  output logic               last
);

  logic [COORD_W-1:0] col, row, w_q, h_q;
  logic [AW-1:0] src_row, dst_row, src_stp_q, dst_stp_q, inc_q;
  logic row_end;

  assign row_end = (col == w_q - 16'd1);
  assign last    = row_end && (row == h_q - 16'd1);

  always_ff @(posedge clk) begin
    if (rst) begin
      col <= '0; row <= '0; w_q <= '0; h_q <= '0;
      src_row <= '0; dst_row <= '0; src_ptr <= '0; dst_ptr <= '0;
      src_stp_q <= '0; dst_stp_q <= '0; inc_q <= '0;
    end else if (load) begin
      col <= '0; row <= '0; w_q <= width; h_q <= height;
      src_row <= src_start; src_ptr <= src_start;
      dst_row <= dst_start; dst_ptr <= dst_start;
      src_stp_q <= src_step; dst_stp_q <= dst_step;
      inc_q <= AW'(bpp);
    end else if (step) begin
      if (row_end) begin
        col     <= '0;
        row     <= row + 16'd1;
        src_row <= src_row + src_stp_q;
        src_ptr <= src_row + src_stp_q;
        dst_row <= dst_row + dst_stp_q;
        dst_ptr <= dst_row + dst_stp_q;
      end else begin
        col     <= col + 16'd1;
        src_ptr <= src_ptr + inc_q;
        dst_ptr <= dst_ptr + inc_q;
      end
    end
  end

endmodule

// File: rtl/rop_rect_copy.sv
module rop_rect_copy
  import rce_pkg::*;
#(
  parameter int AW = 24
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cmd_valid,
  output logic          cmd_ready,
  input  logic [2:0]    cmd_bpp,
  input  logic [7:0]    cmd_rop,
  input  logic          cmd_wr_alpha,
  input  logic          cmd_wr_rgb,
  input  logic [AW-1:0] cmd_src_base,
  input  logic [AW-1:0] cmd_dst_base,
  input  logic [15:0]   cmd_src_pitch,
  input  logic [15:0]   cmd_dst_pitch,
  input  logic [31:0]   cmd_src_xy,
  input  logic [31:0]   cmd_dst_xy1,
  input  logic [31:0]   cmd_dst_xy2,
  output logic          busy,
  output logic          done,
  output logic          err,
  output logic          mem_re,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [2:0]    mem_size,
  output logic [3:0]    mem_be,
  output logic [31:0]   mem_wdata,
  input  logic [31:0]   mem_rdata
);

  rce_state_e st;
  logic busy_q, done_q, err_q;
  logic [2:0] bpp_q;
  logic [7:0] rop_q;
  logic [BYTES_W-1:0] be_q;
  logic [DATA_W-1:0] src_q, rop_out;

  logic legal, empty, last, load;
  logic [COORD_W-1:0] width, height;
  logic [AW-1:0] src_start, dst_start, src_step, dst_step, src_ptr, dst_ptr;
  logic [BYTES_W-1:0] be_new;

  rce_setup #(.AW(AW)) setup_i (
    .bpp(cmd_bpp), .wr_alpha(cmd_wr_alpha), .wr_rgb(cmd_wr_rgb),
    .src_base(cmd_src_base), .dst_base(cmd_dst_base),
    .src_pitch(cmd_src_pitch), .dst_pitch(cmd_dst_pitch),
    .src_xy(cmd_src_xy), .dst_xy1(cmd_dst_xy1), .dst_xy2(cmd_dst_xy2),
    .legal(legal), .empty(empty), .width(width), .height(height),
    .src_start(src_start), .dst_start(dst_start),
    .src_step(src_step), .dst_step(dst_step), .be(be_new)
  );

  assign load = (st == ST_IDLE) && cmd_valid && legal && !empty;

  rce_walk #(.AW(AW)) walk_i (
    .clk(clk), .rst(rst), .load(load), .step(st == ST_WR),
    .bpp(cmd_bpp), .width(width), .height(height),
    .src_start(src_start), .dst_start(dst_start),
    .src_step(src_step), .dst_step(dst_step),
    .src_ptr(src_ptr), .dst_ptr(dst_ptr), .last(last)
  );

  rce_rop #(.DW(DATA_W)) rop_i (
    .code(rop_q), .src(src_q), .dst(mem_rdata), .res(rop_out)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= ST_IDLE; busy_q <= 1'b0; done_q <= 1'b0; err_q <= 1'b0;
      bpp_q <= '0; rop_q <= '0; be_q <= '0; src_q <= '0;
    end else begin
      done_q <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (cmd_valid) begin
            bpp_q <= cmd_bpp;
            rop_q <= cmd_rop;
            be_q  <= be_new;
            if (!legal) begin
              done_q <= 1'b1;
              err_q  <= 1'b1;
            end else if (empty) begin
              done_q <= 1'b1;
              err_q  <= 1'b0;
            end else begin
              err_q  <= 1'b0;
              busy_q <= 1'b1;
              st     <= ST_RD_SRC;
            end
          end
        end
        ST_RD_SRC: st <= ST_RD_DST;
        ST_RD_DST: begin
          src_q <= mem_rdata;
          st    <= ST_WR;
        end
        ST_WR: begin
          if (last) begin
            st     <= ST_IDLE;
            busy_q <= 1'b0;
            done_q <= 1'b1;
          end else begin
            st <= ST_RD_SRC;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign cmd_ready = !busy_q;
  assign busy      = busy_q;
  assign done      = done_q;
  assign err       = err_q;
  assign mem_re    = (st == ST_RD_SRC) || (st == ST_RD_DST);
  assign mem_we    = (st == ST_WR);
  assign mem_addr  = (st == ST_RD_SRC) ? src_ptr : dst_ptr;
  assign mem_size  = bpp_q;
  assign mem_be    = be_q;
  assign mem_wdata = rop_out;

endmodule

// File: rtl/rop_rect_copy_chk.sv
module rop_rect_copy_chk
  import rce_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic       cmd_valid,
  input logic       cmd_ready,
  input logic [2:0] cmd_bpp,
  input logic       cmd_wr_alpha,
  input logic       cmd_wr_rgb,
  input logic       busy,
  input logic       done,
  input logic       err,
  input logic       mem_re,
  input logic       mem_we,
  input logic [2:0] mem_size,
  input logic [3:0] mem_be
);

  logic [3:0] exp_be;

  always_ff @(posedge clk) begin
    if (rst) exp_be <= '0;
    else if (cmd_valid && cmd_ready) exp_be <= store_mask(cmd_bpp, cmd_wr_alpha, cmd_wr_rgb);
  end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!mem_we && !mem_re)); // R8

  AST_HOLD_OFF: assert property (@(posedge clk) disable iff (rst)
    mem_re |-> !cmd_ready); // R8

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R8

  AST_WRITE_AFTER_READ: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> $past(mem_re)); // R3

  AST_REJECT_NO_WALK: assert property (@(posedge clk) disable iff (rst)
    (done && err) |-> (!busy && !$past(busy))); // R7

  AST_STORE_MASK: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> (mem_be == exp_be)); // R5

  AST_SIZE_LEGAL: assert property (@(posedge clk) disable iff (rst)
    (mem_re || mem_we) |-> (mem_size == 3'd1 || mem_size == 3'd2 || mem_size == 3'd4)); // R2

endmodule

bind rop_rect_copy rop_rect_copy_chk chk_i (
  .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .cmd_bpp(cmd_bpp), .cmd_wr_alpha(cmd_wr_alpha), .cmd_wr_rgb(cmd_wr_rgb),
  .busy(busy), .done(done), .err(err), .mem_re(mem_re), .mem_we(mem_we),
  .mem_size(mem_size), .mem_be(mem_be)
);

// File: tb/rop_rect_copy_tb_top.sv
`timescale 1ns/1ps
module rop_rect_copy_tb_top;

  localparam int AW   = 12;
  localparam int MEMB = 1 << AW;
  localparam int MASK = MEMB - 1;

  typedef struct packed {
    logic [2:0]  bpp;
    logic [7:0]  rop;
    logic        wa;
    logic        wr;
    logic [15:0] sb, db, sp, dp, sx, sy, x1, y1, x2, y2;
    logic        xerr;
  } vec_t;

  localparam int NV = 23;
  localparam vec_t VEC [NV] = '{
    '{3'd1, 8'hCC, 1'b1, 1'b1, 16'h000, 16'h800, 16'd16, 16'd16, 16'd1, 16'd1, 16'd2, 16'd3, 16'd7, 16'd6, 1'b0}, // R1 R2 R3 copy 1B
    '{3'd2, 8'h66, 1'b1, 1'b1, 16'h100, 16'h900, 16'd32, 16'd24, 16'd2, 16'd0, 16'd1, 16'd1, 16'd4, 16'd5, 1'b0}, // R1 R2 xor 2B
    '{3'd4, 8'h88, 1'b1, 1'b1, 16'h200, 16'hA00, 16'd64, 16'd48, 16'd0, 16'd2, 16'd3, 16'd0, 16'd6, 16'd3, 1'b0}, // R1 R2 and 4B
    '{3'd4, 8'hCC, 1'b1, 1'b0, 16'h200, 16'hB00, 16'd64, 16'd64, 16'd1, 16'd1, 16'd0, 16'd0, 16'd4, 16'd2, 1'b0}, // R5 alpha only
    '{3'd4, 8'hCC, 1'b0, 1'b1, 16'h200, 16'hC00, 16'd64, 16'd64, 16'd1, 16'd1, 16'd0, 16'd0, 16'd4, 16'd2, 1'b0}, // R5 colour only
    '{3'd1, 8'hCC, 1'b1, 1'b1, 16'h300, 16'hD00, 16'hFFF0, 16'd16, 16'd0, 16'd0, 16'd0, 16'd0, 16'd5, 16'd4, 1'b0}, // R4 flip
    '{3'd2, 8'h11, 1'b1, 1'b1, 16'h100, 16'hE00, 16'd16, 16'd16, 16'd0, 16'd0, 16'd0, 16'd0, 16'd4, 16'd2, 1'b0}, // R1 nor
    '{3'd1, 8'h55, 1'b1, 1'b1, 16'h040, 16'h800, 16'd8, 16'd12, 16'd0, 16'd0, 16'd1, 16'd1, 16'd5, 16'd3, 1'b0}, // R1 invert
    '{3'd2, 8'hFF, 1'b1, 1'b1, 16'h040, 16'h880, 16'd8, 16'd20, 16'd0, 16'd0, 16'd1, 16'd1, 16'd4, 16'd3, 1'b0}, // R1 set
    '{3'd4, 8'h00, 1'b1, 1'b1, 16'h040, 16'h900, 16'd16, 16'd32, 16'd0, 16'd0, 16'd1, 16'd1, 16'd3, 16'd3, 1'b0}, // R1 clear
    '{3'd1, 8'hAA, 1'b1, 1'b1, 16'h040, 16'h980, 16'd8, 16'd8, 16'd0, 16'd0, 16'd0, 16'd0, 16'd6, 16'd2, 1'b0}, // R1 no-op
    '{3'd1, 8'hEE, 1'b1, 1'b1, 16'h040, 16'hA00, 16'd8, 16'd8, 16'd0, 16'd0, 16'd0, 16'd0, 16'd6, 16'd2, 1'b0}, // R1 or
    '{3'd2, 8'h99, 1'b1, 1'b1, 16'h040, 16'hA80, 16'd8, 16'd8, 16'd0, 16'd0, 16'd0, 16'd0, 16'd3, 16'd2, 1'b0}, // R1 equiv
    '{3'd4, 8'h77, 1'b1, 1'b1, 16'h040, 16'hB00, 16'd16, 16'd16, 16'd0, 16'd0, 16'd0, 16'd0, 16'd3, 16'd2, 1'b0}, // R1 nand
    '{3'd1, 8'hCC, 1'b1, 1'b1, 16'h000, 16'h800, 16'd16, 16'd16, 16'd0, 16'd0, 16'd4, 16'd1, 16'd4, 16'd5, 1'b0}, // R6 x2==x1
    '{3'd1, 8'hCC, 1'b1, 1'b1, 16'h000, 16'h800, 16'd16, 16'd16, 16'd0, 16'd0, 16'd1, 16'd5, 16'd4, 16'd2, 1'b0}, // R6 y2<y1
    '{3'd3, 8'hCC, 1'b1, 1'b1, 16'h000, 16'h800, 16'd16, 16'd16, 16'd0, 16'd0, 16'd0, 16'd0, 16'd4, 16'd2, 1'b1}, // R7 size 3
    '{3'd1, 8'hCC, 1'b1, 1'b1, 16'h000, 16'h800, 16'd18, 16'd16, 16'd0, 16'd0, 16'd0, 16'd0, 16'd4, 16'd2, 1'b1}, // R7 src pitch
    '{3'd1, 8'hCC, 1'b1, 1'b1, 16'h000, 16'h800, 16'd16, 16'd10, 16'd0, 16'd0, 16'd0, 16'd0, 16'd4, 16'd2, 1'b1}, // R7 dst pitch
    '{3'd1, 8'hCC, 1'b1, 1'b1, 16'h000, 16'h800, 16'd16, 16'h8004, 16'd0, 16'd0, 16'd0, 16'd0, 16'd4, 16'd2, 1'b1}, // R7 over limit
    '{3'd1, 8'hCC, 1'b1, 1'b1, 16'h000, 16'h800, 16'd16, 16'h8000, 16'd0, 16'd0, 16'd0, 16'd0, 16'd4, 16'd2, 1'b0}, // R7 at limit
    '{3'd0, 8'hCC, 1'b1, 1'b1, 16'h000, 16'h800, 16'd16, 16'd16, 16'd0, 16'd0, 16'd0, 16'd0, 16'd4, 16'd2, 1'b1}, // R7 size 0
    '{3'd2, 8'hCC, 1'b1, 1'b1, 16'h300, 16'hD00, 16'h8000, 16'd16, 16'd0, 16'd0, 16'd0, 16'd0, 16'd3, 16'd3, 1'b0}  // R4 pitch -32768
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic          cmd_valid = 1'b0;
  logic          cmd_ready;
  logic [2:0]    cmd_bpp = '0;
  logic [7:0]    cmd_rop = '0;
  logic          cmd_wr_alpha = 1'b0, cmd_wr_rgb = 1'b0;
  logic [AW-1:0] cmd_src_base = '0, cmd_dst_base = '0;
  logic [15:0]   cmd_src_pitch = '0, cmd_dst_pitch = '0;
  logic [31:0]   cmd_src_xy = '0, cmd_dst_xy1 = '0, cmd_dst_xy2 = '0;
  logic          busy, done, err, mem_re, mem_we;
  logic [AW-1:0] mem_addr;
  logic [2:0]    mem_size;
  logic [3:0]    mem_be;
  logic [31:0]   mem_wdata;
  logic [31:0]   mem_rdata;

  rop_rect_copy #(.AW(AW)) dut_i (.*);

  logic [7:0] mem     [MEMB];
  logic [7:0] ref_mem [MEMB];
  logic init_req = 1'b0, clr_cnt = 1'b0;
  int   seed = 0;
  int   wr_cnt;
  int   cyc = 0;
  int   checks = 0, errors = 0;

  function automatic logic [7:0] pat(int i, int s);
    return 8'((i * 7) ^ (i >> 4) ^ (s * 29 + 3));
  endfunction

  always @(posedge clk) begin
    if (init_req) begin
      for (int i = 0; i < MEMB; i++) mem[i] <= pat(i, seed);
    end else begin
      if (mem_we)
        for (int k = 0; k < 4; k++)
          if (k < int'(mem_size) && mem_be[k]) mem[(int'(mem_addr) + k) & MASK] <= mem_wdata[8*k +: 8];
      if (mem_re)
        for (int k = 0; k < 4; k++)
          mem_rdata[8*k +: 8] <= (k < int'(mem_size)) ? mem[(int'(mem_addr) + k) & MASK] : 8'h00;
    end
    if (clr_cnt) wr_cnt <= 0;
    else if (mem_we) wr_cnt <= wr_cnt + 1;
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      $display("FAIL watchdog: run hung, actual %0d cycles expected fewer", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks + 1, errors + 1);
      $finish;
    end
  end

  task automatic check(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", what, act, act, exp, exp);
    end
  endtask

  task automatic init_mem(input int s);
    @(negedge clk);
    seed = s; init_req = 1'b1; clr_cnt = 1'b1;
    for (int i = 0; i < MEMB; i++) ref_mem[i] = pat(i, s);
    @(negedge clk);
    init_req = 1'b0; clr_cnt = 1'b0;
  endtask

  task automatic apply_ref(input vec_t v);
    int w, h, sp, bpp, sa, da;
    logic [7:0] sbt, dbt, res;
    bit en;
    w = int'(v.x2) - int'(v.x1);
    h = int'(v.y2) - int'(v.y1);
    sp = int'($signed(v.sp));
    bpp = int'(v.bpp);
    if (v.xerr || w <= 0 || h <= 0) return;
    for (int r = 0; r < h; r++)
      for (int c = 0; c < w; c++) begin
        sa = int'(v.sb) + (int'(v.sy) + r) * sp + (int'(v.sx) + c) * bpp;
        da = int'(v.db) + (int'(v.y1) + r) * int'(v.dp) + (int'(v.x1) + c) * bpp;
        for (int k = 0; k < bpp; k++) begin
          sbt = ref_mem[(sa + k) & MASK];
          dbt = ref_mem[(da + k) & MASK];
          for (int b = 0; b < 8; b++) res[b] = v.rop[{1'b0, sbt[b], dbt[b]}];
          en = (bpp != 4) || ((k == 3) ? v.wa : v.wr);
          if (en) ref_mem[(da + k) & MASK] = res;
        end
      end
  endtask

  task automatic issue(input vec_t v);
    cmd_bpp = v.bpp; cmd_rop = v.rop; cmd_wr_alpha = v.wa; cmd_wr_rgb = v.wr;
    cmd_src_base = v.sb[AW-1:0]; cmd_dst_base = v.db[AW-1:0];
    cmd_src_pitch = v.sp; cmd_dst_pitch = v.dp;
    cmd_src_xy = {v.sy, v.sx}; cmd_dst_xy1 = {v.y1, v.x1}; cmd_dst_xy2 = {v.y2, v.x2};
    cmd_valid = 1'b1;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic wait_done(output bit seen);
    seen = 1'b0;
    for (int t = 0; t < 20000 && !seen; t++) begin
      if (done) seen = 1'b1;
      else @(negedge clk);
    end
  endtask

  task automatic run_vec(input int idx);
    vec_t v;
    bit seen;
    int w, h, exp_wr, bad, bad_a;
    v = VEC[idx];
    init_mem(idx + 1);
    apply_ref(v);
    issue(v);
    wait_done(seen);
    check(seen, $sformatf("vec %0d R8 done seen", idx), int'(seen), 1);
    // R6 R7: err flag reports rejection only
    check(err == v.xerr, $sformatf("vec %0d R6/R7 err", idx), int'(err), int'(v.xerr));
    w = int'(v.x2) - int'(v.x1);
    h = int'(v.y2) - int'(v.y1);
    exp_wr = (v.xerr || w <= 0 || h <= 0) ? 0 : w * h;
    // R3 one write per pixel; R6 R7 no writes
    check(wr_cnt == exp_wr, $sformatf("vec %0d R3 write count", idx), wr_cnt, exp_wr);
    bad = 0; bad_a = -1;
    for (int i = 0; i < MEMB; i++)
      if (mem[i] !== ref_mem[i]) begin
        bad++;
        if (bad_a < 0) bad_a = i;
      end
    // R1 R2 R4 R5 memory image
    check(bad == 0, $sformatf("vec %0d R1 R2 R4 R5 memory at 0x%0h", idx, bad_a),
          (bad_a < 0) ? 0 : int'(mem[bad_a]), (bad_a < 0) ? 0 : int'(ref_mem[bad_a]));
  endtask

  initial begin
    vec_t big, rej;
    bit seen, hold_ok;
    int held_err;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R9 reset state
    check(busy == 1'b0, "R9 busy after reset", int'(busy), 0);
    check(cmd_ready == 1'b1, "R9 cmd_ready after reset", int'(cmd_ready), 1);
    check(done == 1'b0 && err == 1'b0, "R9 done/err after reset", int'({done, err}), 0);
    check(mem_re == 1'b0 && mem_we == 1'b0, "R9 memory idle after reset", int'({mem_re, mem_we}), 0);

    for (int n = 0; n < NV; n++) run_vec(n);

    // R8 back-pressure across a long walk
    big = '{3'd1, 8'hCC, 1'b1, 1'b1, 16'h000, 16'h800, 16'd16, 16'd16,
            16'd0, 16'd0, 16'd0, 16'd0, 16'd16, 16'd16, 1'b0};
    init_mem(77);
    issue(big);
    hold_ok = 1'b1;
    seen = 1'b0;
    for (int t = 0; t < 5000 && !seen; t++) begin
      if (done) seen = 1'b1;
      else begin
        if (cmd_ready !== 1'b0 || busy !== 1'b1) hold_ok = 1'b0;
        @(negedge clk);
      end
    end
    check(seen && hold_ok, "R8 ready low while busy", int'(hold_ok), 1);
    check(wr_cnt == 256, "R3 writes for 16x16", wr_cnt, 256);
    check(busy == 1'b0 && cmd_ready == 1'b1, "R8 idle at done", int'({busy, cmd_ready}), 1);
    @(negedge clk);
    check(done == 1'b0, "R8 done is one cycle", int'(done), 0);

    // R8 err holds until next accept
    rej = VEC[16];
    init_mem(90);
    issue(rej);
    wait_done(seen);
    repeat (5) @(negedge clk);
    held_err = int'(err);
    check(held_err == 1, "R8 err held while idle", held_err, 1);
    issue(VEC[0]);
    check(err == 1'b0, "R8 err cleared by accept", int'(err), 0);
    wait_done(seen);
    check(seen && err == 1'b0, "R8 legal after reject", int'(err), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule